// File: doc/BRIEF.md
# Paired-Line Single-Port Stream FIFO

This block is a synchronous first-in first-out buffer for 32-bit words. A producer hands it one word per clock and a consumer takes one word per clock, and both may move in the same cycle. The storage behind it is one single-port memory whose lines are twice the word width and whose line count is half the logical depth. The nominal build holds 256K words in 128K lines of 64 bits. The parameter default is smaller so that elaboration stays cheap.

The memory is used in strict order, never at random. Because of that, two consecutive words can share one line. A small write-side queue of up to three words gathers words into pairs and commits a pair in one memory access. A read-side line register takes one line at a time and serves its low half first, then its high half. One access per cycle is enough for both sides, because each side needs the port at most every second cycle. When a side waits for the port, the staging registers carry the word that arrives in the meantime. When the memory holds no lines, the read side takes its words straight from the write-side queue. A single unpaired word therefore never waits for a partner.

Both data interfaces use valid/ready. A word moves on the input when `in_valid` and `in_ready` are both high at a rising edge. A word moves on the output when `out_valid` and `out_ready` are both high at a rising edge. While `out_valid` is high and `out_ready` is low, the output word and its valid are held. `in_ready` never depends on `in_valid`, so the producer may wait for ready before it raises valid. `in_ready` does depend on `out_ready` when the buffer is full.

Top module: `wspf_fifo`

## Requirements
- R1: `in_ready` is high in every cycle in which `full` is low. While `full` is high, `in_ready` equals `out_valid && out_ready` of the same cycle.
- R2: Words leave in exactly the order they were accepted, with their values unchanged. The older word of a line is held in its low half.
- R3: When a push and a pop both happen in one cycle, `count` is unchanged afterwards, and this includes the full state.
- R4: `count` equals the number of accepted words not yet popped. `full` is high exactly when `count` equals DEPTH, and `empty` is high exactly when `count` is zero.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value in the next cycle.
- R6: A word pushed into an empty buffer is offered on `out_valid`/`out_data` after the second rising edge, counting the edge that accepts it.
- R7: A single buffered word with no partner can be popped without any further push.
- R8: Whenever `count` is at least 2 in a cycle, `out_valid` is high in the next cycle. This makes one pop per clock sustainable.
- R9: A push offered while the buffer is full and no pop happens is refused, and the stored words stay intact. The memory is never written when all its lines are in use.
- R10: A pop attempt while empty has no effect: `out_valid` stays low and `count` stays zero.
- R11: A synchronous active-high `rst` leaves `count` at 0, `empty` high, `full` low, `out_valid` low and `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Buffer can take a word this cycle |
| in_data | input | DATA_W | Word to store |
| out_valid | output | 1 | `out_data` holds the oldest word |
| out_ready | input | 1 | Consumer takes `out_data` this cycle |
| out_data | output | DATA_W | Oldest stored word, from a register |
| count | output | $clog2(DEPTH+1) | Words currently stored |
| full | output | 1 | `count` equals DEPTH |
| empty | output | 1 | `count` is zero |

## Verification
The bench first pushes one word into an empty buffer and pops it with no partner word. A design that waited for a pair, or that took the wrong path past the memory, would never raise `out_valid` or would raise it in the wrong cycle. It then fills the buffer to DEPTH and offers a push with no pop, followed by a push together with a pop. A design with a wrong `in_ready` gate would overwrite a stored line or drop the concurrent word, and the word order seen during the drain would then be wrong. Randomly biased phases hold the buffer near empty, near full and in a sustained stream. These phases make the write commit and the read fetch ask for the port in the same cycle, so losing a pair or stalling for a cycle would show up as a data mismatch or as a missing `out_valid`.

// File: rtl/wspf_pkg.sv
package wspf_pkg;

  // Which side owns the single memory port in a cycle.
  typedef enum logic [1:0] {
    PORT_IDLE   = 2'd0,
    PORT_FETCH  = 2'd1,
    PORT_COMMIT = 2'd2
  } port_op_e;

  // Word slots in the write-side gathering queue: one pair plus one spill word.
  localparam int unsigned WR_SLOTS = 3;

endpackage

// File: rtl/wspf_line_ram.sv
module wspf_line_ram #(
  parameter int unsigned LINE_W = 64,
  parameter int unsigned LINES  = 512,
  localparam int unsigned AW    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [LINE_W-1:0] wdata,
  output logic [LINE_W-1:0] rdata
);

  logic [LINE_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // The read line is captured by the read stage register on the same edge.
  assign rdata = mem[addr];

endmodule

// File: rtl/wspf_wr_stage.sv
module wspf_wr_stage
  import wspf_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic [1:0]   take,
  output logic [W-1:0] w0,
  output logic [W-1:0] w1,
  output logic [1:0]   cnt
);

  logic [W-1:0] q  [WR_SLOTS];
  logic [W-1:0] nq [WR_SLOTS];
  logic [1:0]   cnt_q, cnt_n;

  always_comb begin
    for (int i = 0; i < WR_SLOTS; i++) begin
      nq[i] = '0;
      for (int j = 0; j < WR_SLOTS; j++) begin
        if (j == i + int'(take)) nq[i] = q[j];
      end
    end
    if (push) begin
      for (int i = 0; i < WR_SLOTS; i++) begin
        if (i == int'(cnt_q) - int'(take)) nq[i] = din;
      end
    end
    cnt_n = cnt_q - take + {1'b0, push};
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WR_SLOTS; i++) q[i] <= nq[i];
  end

  assign w0  = q[0];
  assign w1  = q[1];
  assign cnt = cnt_q;

endmodule

// File: rtl/wspf_rd_stage.sv
module wspf_rd_stage #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pop,
  input  logic           load,
  input  logic [2*W-1:0] load_line,
  input  logic [1:0]     load_cnt,
  output logic [W-1:0]   dout,
  output logic [1:0]     cnt
);

  logic [2*W-1:0] line_q;
  logic [1:0]     cnt_q;
  logic           half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_cnt;
      half_q <= 1'b0;
    end else if (pop) begin
      cnt_q  <= cnt_q - 2'd1;
      half_q <= ~half_q;
    end
  end

  always_ff @(posedge clk) begin
    if (load) line_q <= load_line;
  end

  assign dout = half_q ? line_q[2*W-1:W] : line_q[W-1:0];
  assign cnt  = cnt_q;

endmodule

// File: rtl/wspf_fifo.sv
module wspf_fifo
  import wspf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned LINES = DEPTH / 2,
  localparam int unsigned LAW   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int unsigned LCW   = $clog2(LINES + 1),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  logic [1:0]          rd_cnt, wr_cnt, take, wr_left, load_cnt;
  logic [DATA_W-1:0]   w0, w1;
  logic [2*DATA_W-1:0] mem_rdata, load_line;
  logic [LCW-1:0]      lines_q;
  logic [LAW-1:0]      wr_line_q, rd_line_q, ram_addr;
  logic [CNT_W-1:0]    count_q;
  logic                pop_fire, push_fire, need_fill, bypass, load;
  port_op_e            port_op;

  assign out_valid = (rd_cnt != 2'd0);
  assign pop_fire  = out_valid && out_ready;
  assign need_fill = (rd_cnt == 2'd0) || (rd_cnt == 2'd1 && pop_fire);
  assign bypass    = need_fill && (lines_q == '0) && (wr_cnt != 2'd0);

  // The read side wins the port; a waiting pair spills its next word into slot 2.
  always_comb begin
    if (need_fill && lines_q != '0)       port_op = PORT_FETCH;
    else if (!bypass && wr_cnt >= 2'd2)   port_op = PORT_COMMIT;
    else                                  port_op = PORT_IDLE;
  end

  always_comb begin
    if (port_op == PORT_COMMIT) take = 2'd2;
    else if (bypass)            take = (wr_cnt >= 2'd2) ? 2'd2 : 2'd1;
    else                        take = 2'd0;
  end

  assign wr_left   = wr_cnt - take;
  assign in_ready  = (wr_left < 2'd3) && ((count_q < CNT_W'(DEPTH)) || pop_fire);
  assign push_fire = in_valid && in_ready;

  assign load      = (port_op == PORT_FETCH) || bypass;
  assign load_line = (port_op == PORT_FETCH) ? mem_rdata : {w1, w0};
  assign load_cnt  = (port_op == PORT_FETCH) ? 2'd2 : take;
  assign ram_addr  = (port_op == PORT_FETCH) ? rd_line_q : wr_line_q;

  function automatic logic [LAW-1:0] next_line(input logic [LAW-1:0] p);
    return (p == LAW'(LINES - 1)) ? '0 : p + LAW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q   <= '0;
      wr_line_q <= '0;
      rd_line_q <= '0;
      count_q   <= '0;
    end else begin
      if (port_op == PORT_COMMIT) wr_line_q <= next_line(wr_line_q);
      if (port_op == PORT_FETCH)  rd_line_q <= next_line(rd_line_q);
      lines_q <= lines_q + LCW'(port_op == PORT_COMMIT) - LCW'(port_op == PORT_FETCH);
      count_q <= count_q + CNT_W'(push_fire) - CNT_W'(pop_fire);
    end
  end

  wspf_wr_stage #(.W(DATA_W)) u_wr (
    .clk  (clk),
    .rst  (rst),
    .push (push_fire),
    .din  (in_data),
    .take (take),
    .w0   (w0),
    .w1   (w1),
    .cnt  (wr_cnt)
  );

  wspf_line_ram #(.LINE_W(2 * DATA_W), .LINES(LINES)) u_ram (
    .clk   (clk),
    .we    (port_op == PORT_COMMIT),
    .addr  (ram_addr),
    .wdata ({w1, w0}),
    .rdata (mem_rdata)
  );

  wspf_rd_stage #(.W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .pop       (pop_fire),
    .load      (load),
    .load_line (load_line),
    .load_cnt  (load_cnt),
    .dout      (out_data),
    .cnt       (rd_cnt)
  );

  assign count = count_q;
  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);

endmodule

// File: rtl/wspf_fifo_chk.sv
module wspf_fifo_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned LINES  = 512,
  parameter int unsigned LCW    = 10,
  parameter int unsigned CNT_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  count,
  input logic              full,
  input logic              empty,
  input logic              mem_we,
  input logic [LCW-1:0]    lines
);

  // R1
  ready_when_room_chk: assert property (@(posedge clk) disable iff (rst)
    !full |-> in_ready);

  // R1
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !(out_valid && out_ready)) |-> !in_ready);

  // R3
  pair_count_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_valid && out_ready) |=> $stable(count));

  // R4
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !out_valid);

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  stream_chk: assert property (@(posedge clk) disable iff (rst)
    (count >= CNT_W'(2)) |=> out_valid);

  // R9
  line_room_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (lines < LCW'(LINES)));

endmodule

bind wspf_fifo wspf_fifo_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .LINES  (LINES),
  .LCW    (LCW),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .count     (count),
  .full      (full),
  .empty     (empty),
  .mem_we    (port_op == wspf_pkg::PORT_COMMIT),
  .lines     (lines_q)
);

// File: tb/test_wspf_fifo.sv
`timescale 1ns/1ps
module test_wspf_fifo;
  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, full, empty;
  logic [DW-1:0] out_data;
  logic [CW-1:0] count;

  always #2.5 clk = ~clk;

  wspf_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_wspf_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .count(count), .full(full), .empty(empty)
  );

  int            checks = 0, errors = 0;
  logic [DW-1:0] model [$];
  bit            prev_ge2 = 0, hold = 0, done = 0;
  logic [DW-1:0] held, s_od;
  logic          s_ov;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ready(input int sz, input bit pop);
    return (sz < DEPTH) || pop;
  endfunction

  task automatic step(input logic iv, input logic [DW-1:0] id, input logic ordy);
    bit pf, qf;
    int sz;
    @(negedge clk);
    in_valid = iv; in_data = id; out_ready = ordy;
    #1;
    sz = model.size();
    s_ov = out_valid; s_od = out_data;
    chk(count == CW'(sz), "R4 count", 64'(count), 64'(sz));
    chk(full == (sz == DEPTH), "R4 full", 64'(full), 64'(sz == DEPTH));
    chk(empty == (sz == 0), "R4 empty", 64'(empty), 64'(sz == 0));
    chk(in_ready == exp_ready(sz, out_valid && ordy), "R1 in_ready", 64'(in_ready),
        64'(exp_ready(sz, out_valid && ordy)));
    if (prev_ge2) chk(out_valid, "R8 out_valid after two words", 64'(out_valid), 64'd1);
    if (hold) chk(out_valid && out_data == held, "R5 held word", 64'(out_data), 64'(held));
    if (out_valid) begin
      if (sz == 0) chk(1'b0, "R10 valid while empty", 64'(out_valid), 64'd0);
      else         chk(out_data == model[0], "R2 order", 64'(out_data), 64'(model[0]));
    end
    pf = iv && in_ready;
    qf = out_valid && ordy;
    hold = out_valid && !ordy;
    held = out_data;
    prev_ge2 = (sz >= 2);
    @(posedge clk);
    if (qf && sz > 0) void'(model.pop_front());
    if (pf) model.push_back(id);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p_push, p_pop, guard;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    chk(count == 0 && empty && !full, "R11 reset flags", 64'(count), 64'd0);
    chk(!out_valid && in_ready, "R11 reset handshake", {62'd0, out_valid, in_ready}, 64'd1);

    // R6 / R7: lone word into empty buffer
    step(1'b1, 32'hA5A5_0001, 1'b0);
    step(1'b0, '0, 1'b0);
    chk(s_ov == 1'b0, "R6 not yet visible", 64'(s_ov), 64'd0);
    step(1'b0, '0, 1'b1);
    chk(s_ov == 1'b1 && s_od == 32'hA5A5_0001, "R6 R7 lone word", 64'(s_od), 64'hA5A5_0001);
    step(1'b0, '0, 1'b0);
    chk(count == 0, "R7 drained", 64'(count), 64'd0);

    // R10 pops on empty
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
    chk(count == 0 && !s_ov, "R10 empty pops ignored", 64'(count), 64'd0);

    // Fill to full, then refused push (R9), then push with pop while full (R3)
    for (int i = 0; i < DEPTH; i++) step(1'b1, $urandom, 1'b0);
    step(1'b1, 32'hDEAD_BEEF, 1'b0);
    step(1'b0, '0, 1'b0);
    chk(count == CW'(DEPTH) && full, "R9 full push refused", 64'(count), 64'(DEPTH));
    step(1'b1, 32'h1234_5678, 1'b1);
    step(1'b0, '0, 1'b0);
    chk(count == CW'(DEPTH), "R3 full push+pop count", 64'(count), 64'(DEPTH));
    guard = 0;
    while (model.size() > 0 && guard < 4 * DEPTH) begin
      step(1'b0, '0, 1'b1);
      guard++;
    end
    step(1'b0, '0, 1'b0);
    chk(count == 0, "R2 full drain", 64'(count), 64'd0);

    // Sustained stream (R8, R3)
    for (int i = 0; i < 4; i++) step(1'b1, $urandom, 1'b0);
    for (int i = 0; i < 300; i++) step(1'b1, $urandom, 1'b1);

    // Biased random phases: near empty, near full, balanced
    for (int ph = 0; ph < 6; ph++) begin
      case (ph % 3)
        0:       begin p_push = 30; p_pop = 80; end
        1:       begin p_push = 85; p_pop = 30; end
        default: begin p_push = 60; p_pop = 60; end
      endcase
      for (int i = 0; i < 600; i++)
        step(($urandom_range(99) < p_push), $urandom, ($urandom_range(99) < p_pop));
    end

    guard = 0;
    while (model.size() > 0 && guard < 4 * DEPTH) begin
      step(1'b0, '0, 1'b1);
      guard++;
    end
    step(1'b0, '0, 1'b0);
    chk(count == 0 && empty, "R4 final empty", 64'(count), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule